// File: doc/BRIEF.md
# Bidirectional Scan-Line Shift Register

This block drives the row (common) side of a dot-matrix display. It holds a chain of scan stages, 240 by default. The chain moves one place each time the line pulse falls. One stage output feeds each row driver. A stage holding 1 means that row is selected, and 0 means it is not selected.

Two configuration pins set the shift order. `dual_mode` splits the chain into two halves of equal length, each fed from its own end pin. `reverse` runs the shift from the high-numbered stages toward the low-numbered ones.

The two end pins are bidirectional, and each one is modelled as an input, an output value and an output enable. In single mode, whichever pin feeds the chain is the input. The other pin carries the last stage out so that parts can be cascaded. In dual mode both end pins are inputs.

Pulling the active-low display-off input low clears the whole chain at once. The clear does not wait for a clock edge.

Top module: `scan_shift_top`

## Requirements
- R1: While `rst_n` or `disp_off_n` is low, every bit of `row_sel` is 0. This clear takes effect without a clock edge.
- R2: The chain advances exactly once for each falling edge of `line_pulse`, and the new state appears one `clk` rising edge after `line_pulse` is first sampled low. A rising edge of `line_pulse`, or holding it at a level, leaves `row_sel` unchanged.
- R3: Single forward (`dual_mode`=0, `reverse`=0): `row_sel[0]` loads `end1_in`, and each `row_sel[k]` loads `row_sel[k-1]`. `end2_oe`=1 and `end2_out`=`row_sel[N-1]`. `end1_oe`=0.
- R4: Single reverse (`dual_mode`=0, `reverse`=1): `row_sel[N-1]` loads `end2_in`, and each `row_sel[k]` loads `row_sel[k+1]`. `end1_oe`=1 and `end1_out`=`row_sel[0]`. `end2_oe`=0.
- R5: Dual forward (`dual_mode`=1, `reverse`=0): `row_sel[0]` loads `end1_in` and `row_sel[N/2]` loads `end2_in`. Every other stage loads `row_sel[k-1]`. A 1 leaving `row_sel[N/2-1]` does not enter the upper half.
- R6: Dual reverse (`dual_mode`=1, `reverse`=1): `row_sel[N-1]` loads `end2_in` and `row_sel[N/2-1]` loads `end1_in`. Every other stage loads `row_sel[k+1]`. A 1 leaving `row_sel[N/2]` does not enter the lower half.
- R7: At most one end-pin output enable is high at any time. In single mode exactly one is high, and in dual mode neither is.
- R8: While `disp_off_n` is low, falling edges of `line_pulse` do not load any stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the line pulse |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_pulse | input | 1 | Line pulse; the chain advances on its falling edge |
| disp_off_n | input | 1 | Active-low display-off; clears the chain asynchronously |
| dual_mode | input | 1 | 1 = two half-length chains, 0 = one full chain |
| reverse | input | 1 | 1 = shift from high stage index toward low |
| end1_in | input | 1 | Input value of the low-end pin |
| end1_out | output | 1 | Output value of the low-end pin |
| end1_oe | output | 1 | Output enable of the low-end pin |
| end2_in | input | 1 | Input value of the high-end pin |
| end2_out | output | 1 | Output value of the high-end pin |
| end2_oe | output | 1 | Output enable of the high-end pin |
| row_sel | output | NSTAGE | Stage outputs to the row drivers, index k = row k+1 |

## Verification
Each stage sits directly behind `row_sel`, so a wrong stage value shows up on the ports one clock edge after the line pulse that caused it. Walking a single 1 through each of the four orders shows up a wrong neighbour selection at the first stage it affects. A wrong split point in dual mode appears at the pulse where the token would leak into the other half. A wrong end-pin role shows up immediately on the enables. A bad output value appears on the pulse that brings the token into the last stage.

// File: rtl/scan_shift_pkg.sv
package scan_shift_pkg;

  typedef enum logic [1:0] {
    SRC_LOWER = 2'd0,
    SRC_UPPER = 2'd1,
    SRC_END1  = 2'd2,
    SRC_END2  = 2'd3
  } stage_src_e;

  // Where stage k takes its next value from, for an n-stage chain.
  function automatic stage_src_e stage_src(input int k, input int n,
                                           input logic dual, input logic rev);
    int half;
    half = n / 2;
    if (!rev) begin
      if (k == 0)                 return SRC_END1;
      else if (dual && k == half) return SRC_END2;
      else                        return SRC_LOWER;
    end else begin
      if (k == n - 1)                 return SRC_END2;
      else if (dual && k == half - 1) return SRC_END1;
      else                            return SRC_UPPER;
    end
  endfunction

  function automatic logic pick_src(input stage_src_e s, input logic lo,
                                    input logic hi, input logic e1, input logic e2);
    case (s)
      SRC_LOWER: return lo;
      SRC_UPPER: return hi;
      SRC_END1:  return e1;
      default:   return e2;
    endcase
  endfunction

endpackage

// File: rtl/lp_fall_detect.sv
module lp_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line_pulse,
  output logic fall
);
  logic lp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= line_pulse;
  end

  assign fall = lp_q & ~line_pulse;

  // R2: a detected fall means high one sample ago, low now
  a_r2_fall_is_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> ($past(line_pulse) && !line_pulse));

endmodule

// File: rtl/scan_chain.sv
module scan_chain import scan_shift_pkg::*; #(
  parameter int NSTAGE = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              shift_en,
  input  logic              dual_mode,
  input  logic              reverse,
  input  logic              end1_in,
  input  logic              end2_in,
  output logic [NSTAGE-1:0] q
);
  logic [NSTAGE-1:0] nxt;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic lo_v, hi_v;
    if (k == 0) begin : g_lo0
      assign lo_v = 1'b0;
    end else begin : g_lo
      assign lo_v = q[k-1];
    end
    if (k == NSTAGE - 1) begin : g_hiN
      assign hi_v = 1'b0;
    end else begin : g_hi
      assign hi_v = q[k+1];
    end
    assign nxt[k] = pick_src(stage_src(k, NSTAGE, dual_mode, reverse),
                             lo_v, hi_v, end1_in, end2_in);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        q <= '0;
    else if (shift_en) q <= nxt;
  end

  // R1 / R8: display-off holds every stage clear
  a_r1_clear_held: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (q == '0));

  // R2: no shift request, no change (unless cleared meanwhile)
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && clr_n) |=> ($stable(q) || q == '0));

  // R3: single forward moves every stage one place up
  a_r3_fwd_move: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && clr_n && !dual_mode && !reverse) |=>
      ((q[NSTAGE-1:1] == $past(q[NSTAGE-2:0]) && q[0] == $past(end1_in)) || q == '0));

  // R4: single reverse moves every stage one place down
  a_r4_rev_move: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && clr_n && !dual_mode && reverse) |=>
      ((q[NSTAGE-2:0] == $past(q[NSTAGE-1:1]) && q[NSTAGE-1] == $past(end2_in)) || q == '0));

endmodule

// File: rtl/end_pin_ctrl.sv
module end_pin_ctrl #(
  parameter int NSTAGE = 240
) (
  input  logic              dual_mode,
  input  logic              reverse,
  input  logic [NSTAGE-1:0] q,
  output logic              end1_out,
  output logic              end1_oe,
  output logic              end2_out,
  output logic              end2_oe
);
  // Single mode: the pin opposite the feeding pin carries the far-end stage.
  assign end1_oe  = !dual_mode &&  reverse;
  assign end2_oe  = !dual_mode && !reverse;
  assign end1_out = end1_oe & q[0];
  assign end2_out = end2_oe & q[NSTAGE-1];
endmodule

// File: rtl/scan_shift_top.sv
module scan_shift_top #(
  parameter int NSTAGE = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pulse,
  input  logic              disp_off_n,
  input  logic              dual_mode,
  input  logic              reverse,
  input  logic              end1_in,
  output logic              end1_out,
  output logic              end1_oe,
  input  logic              end2_in,
  output logic              end2_out,
  output logic              end2_oe,
  output logic [NSTAGE-1:0] row_sel
);
  localparam int HALF = NSTAGE / 2;

  logic lp_fall;
  logic clr_n;

  assign clr_n = rst_n & disp_off_n;

  lp_fall_detect u_edge (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .fall(lp_fall)
  );

  scan_chain #(.NSTAGE(NSTAGE)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .shift_en(lp_fall),
    .dual_mode(dual_mode), .reverse(reverse),
    .end1_in(end1_in), .end2_in(end2_in), .q(row_sel)
  );

  end_pin_ctrl #(.NSTAGE(NSTAGE)) u_pins (
    .dual_mode(dual_mode), .reverse(reverse), .q(row_sel),
    .end1_out(end1_out), .end1_oe(end1_oe),
    .end2_out(end2_out), .end2_oe(end2_oe)
  );

  // R7: never both end pins driving; exactly one in single mode
  a_r7_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end1_oe, end2_oe}));
  a_r7_single_one: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |-> ($countones({end1_oe, end2_oe}) == 1));

  // R3: forward cascade pin carries the top stage
  a_r3_end2_val: assert property (@(posedge clk) disable iff (!rst_n)
    end2_oe |-> (end2_out == row_sel[NSTAGE-1]));

  // R5: dual forward keeps halves apart: the upper half base loads end2_in
  a_r5_split: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_fall && clr_n && dual_mode && !reverse) |=>
      (row_sel[HALF] == $past(end2_in) || row_sel == '0));

  // R6: dual reverse: the lower half top loads end1_in
  a_r6_split: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_fall && clr_n && dual_mode && reverse) |=>
      (row_sel[HALF-1] == $past(end1_in) || row_sel == '0));

endmodule

// File: tb/tb_scan_shift_top.sv
module tb_scan_shift_top;
  localparam int N = 240;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst_n, line_pulse, disp_off_n, dual_mode, reverse, end1_in, end2_in;
  logic end1_out, end1_oe, end2_out, end2_oe;
  logic [N-1:0] row_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  scan_shift_top #(.NSTAGE(N)) dut (
    .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .disp_off_n(disp_off_n),
    .dual_mode(dual_mode), .reverse(reverse),
    .end1_in(end1_in), .end1_out(end1_out), .end1_oe(end1_oe),
    .end2_in(end2_in), .end2_out(end2_out), .end2_oe(end2_oe),
    .row_sel(row_sel)
  );

  task automatic chk_vec(input string req, input logic [N-1:0] exp);
    n_chk++;
    if (row_sel !== exp) begin
      n_bad++;
      $display("FAIL %s row_sel actual=%h expected=%h", req, row_sel, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Falling edge lands before a posedge; sample at the following negedge.
  task automatic pulse();
    @(negedge clk) line_pulse = 1'b1;
    @(negedge clk) line_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic restart(input logic dm, input logic rv);
    @(negedge clk);
    rst_n = 1'b0; dual_mode = dm; reverse = rv; end1_in = 0; end2_in = 0;
    line_pulse = 0; disp_off_n = 1;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R3: token walks from stage 0 upward and leaves through end2_out
  task automatic t_single_fwd();
    logic [N-1:0] e;
    restart(0, 0);
    chk_bit("R3", "end1_oe", end1_oe, 1'b0);
    chk_bit("R3", "end2_oe", end2_oe, 1'b1);
    end1_in = 1; pulse(); end1_in = 0;
    e = '0; e[0] = 1'b1;
    chk_vec("R3", e);
    for (int p = 1; p <= N; p++) begin
      pulse();
      e = '0; if (p < N) e[p] = 1'b1;
      chk_vec("R3", e);
      if (p == N - 1) chk_bit("R3", "end2_out", end2_out, 1'b1);
    end
  endtask

  // R4: token walks from stage N-1 downward, leaving through end1_out
  task automatic t_single_rev();
    logic [N-1:0] e;
    restart(0, 1);
    chk_bit("R4", "end1_oe", end1_oe, 1'b1);
    chk_bit("R4", "end2_oe", end2_oe, 1'b0);
    end2_in = 1; pulse(); end2_in = 0;
    e = '0; e[N-1] = 1'b1;
    chk_vec("R4", e);
    for (int p = 1; p <= N; p++) begin
      pulse();
      e = '0; if (p < N) e[N-1-p] = 1'b1;
      chk_vec("R4", e);
      if (p == N - 1) chk_bit("R4", "end1_out", end1_out, 1'b1);
    end
  endtask

  // R5: two tokens, one per half, never crossing the split
  task automatic t_dual_fwd();
    logic [N-1:0] e;
    restart(1, 0);
    chk_bit("R7", "dual oe", end1_oe | end2_oe, 1'b0);
    end1_in = 1; end2_in = 1; pulse(); end1_in = 0; end2_in = 0;
    for (int p = 1; p <= H; p++) begin
      pulse();
      e = '0;
      if (p < H) begin e[p] = 1'b1; e[H+p] = 1'b1; end
      chk_vec("R5", e);
    end
  endtask

  // R6: dual reverse, tokens enter at N-1 and H-1
  task automatic t_dual_rev();
    logic [N-1:0] e;
    restart(1, 1);
    chk_bit("R7", "dual oe", end1_oe | end2_oe, 1'b0);
    end1_in = 1; pulse(); end1_in = 0;
    e = '0; e[H-1] = 1'b1;
    chk_vec("R6", e);
    end2_in = 1; pulse(); end2_in = 0;
    e = '0; e[H-2] = 1'b1; e[N-1] = 1'b1;
    chk_vec("R6", e);
    for (int p = 2; p <= H; p++) begin
      pulse();
      e = '0;
      if (p < H) e[H-1-p] = 1'b1;
      if (p - 1 < H) e[N-p] = 1'b1;
      chk_vec("R6", e);
    end
  endtask

  // R1, R2, R8: async clear, level/rising-edge no effect, no load while off
  task automatic t_clear_and_edges();
    logic [N-1:0] e;
    restart(0, 0);
    chk_vec("R1", '0);
    end1_in = 1; pulse(); pulse(); end1_in = 0;
    e = '0; e[0] = 1; e[1] = 1;
    chk_vec("R2", e);
    @(negedge clk) line_pulse = 1'b1;
    repeat (3) @(negedge clk);
    chk_vec("R2", e);
    @(negedge clk) line_pulse = 1'b0;
    @(negedge clk);
    e = '0; e[1] = 1; e[2] = 1;
    chk_vec("R2", e);
    @(posedge clk); #1 disp_off_n = 1'b0;
    #0.5;
    chk_vec("R1", '0);
    end1_in = 1; pulse(); pulse();
    chk_vec("R8", '0);
    @(negedge clk) disp_off_n = 1'b1; end1_in = 0;
    pulse();
    chk_vec("R8", '0);
  endtask

  initial begin
    rst_n = 0; line_pulse = 0; disp_off_n = 1; dual_mode = 0; reverse = 0;
    end1_in = 0; end2_in = 0;
    t_clear_and_edges();
    t_single_fwd();
    t_single_rev();
    t_dual_fwd();
    t_dual_rev();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not complete actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule